// File: doc/BRIEF.md
# Converter configuration SPI master

This block is a four-wire SPI master for setting up external data converters and clock chips. A parallel request carries a routing byte, a read/write flag, two width bits, a 13-bit register address, a write byte and a target number. On a start request the block sends one fixed 32-bit frame, most significant bit first, with the addressed slave's active-low select held for the whole frame. The routing byte leads every frame so that intermediate logic can steer the command to the right device. The read/write flag, the width bits and the address form a 16-bit instruction, and the data byte comes last.

The serial clock is the system clock divided by five: three cycles low, then two cycles high. The clock idles low. Data leaves on falling edges and is sampled on rising edges. An output-enable marks when the master owns the data line, so that an external bidirectional pad can serve three-wire parts. On a read the enable drops for the final byte, and that byte is returned with a one-cycle completion pulse.

Top module: `cnv_spi_master`

## Requirements
- R1: The frame is 32 bits long and is sent MSB first on `mosi`. Bits 31..24 carry `presel`, bit 23 carries `rw` (1 = read), bits 22..21 carry `width`, bits 20..8 carry `addr` and bits 7..0 carry `wdata`.
- R2: `sclk` is low while idle. During a frame each bit lasts 5 system clocks: `sclk` is low for 3 of them and then high for 2. A frame has exactly 32 rising edges.
- R3: `mosi` holds each bit from the falling edge that ends the previous bit, or from the start of the frame for bit 31, through that bit's high phase. It never changes while `sclk` is high or on a rising edge.
- R4: For a read, `miso` is sampled on each rising edge. `rdata` takes the values sampled on the last 8 rising edges, first sample in bit 7, and becomes valid in the cycle of `done`.
- R5: A `tgt` value of 0, 1 or 2 pulls only `cs_n[tgt]` low. A value of 3 pulls no select low, but the frame still runs. At most one select is ever low.
- R6: The select goes low in the cycle after the start is accepted, which is 3 system clocks before the first rising edge. It returns high 3 system clocks after the last falling edge.
- R7: `oe` is high from the start of the frame until the select rises for a write. For a read it falls at the falling edge that ends the 24th bit. It is low while idle.
- R8: A start is accepted only when `busy` is low. `busy` is high from the next cycle for 168 cycles. A start while `busy` is high has no effect.
- R9: `done` is a single-cycle pulse in the cycle the select rises. Then `busy` stays high for 4 more cycles, so that at least one serial-clock period passes before the next frame.
- R10: A write frame leaves `rdata` unchanged.
- R11: While `rst_n` is low, all selects are high, `sclk`, `oe`, `busy` and `done` are low, and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request a frame (taken when idle) |
| tgt | input | 2 | Target slave number |
| presel | input | 8 | Routing byte |
| rw | input | 1 | 1 = read, 0 = write |
| width | input | 2 | Instruction width bits |
| addr | input | 13 | Register start address |
| wdata | input | 8 | Write data byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| sclk | output | 1 | Serial clock |
| cs_n | output | 3 | Active-low slave selects |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| oe | output | 1 | High while the master drives the shared data line |

## Verification
The hardest situations to reach from the ports are the edges of the busy window. One is a start that is held through a whole frame and then accepted on the first idle edge. Another is a start that arrives during the gap after the select rises. The bench holds `start` high across two frames in a row and also fires competing requests in the middle of a frame, with different targets and addresses. A behavioural slave shifts a chosen word on `sclk` falling edges. This checks the turnaround of the read byte and shows that `rdata` survives the write frames that follow.

// File: rtl/cnv_spi_pkg.sv
package cnv_spi_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_HOLD  = 2'd2,
    SEQ_GAP   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/cnv_spi_phase.sv
module cnv_spi_phase #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            clr,
  input  logic [PH_W-1:0] lim,
  output logic [PH_W-1:0] ph,
  output logic            wrap
);
  logic [PH_W-1:0] ph_q, ph_d;

  assign wrap = (ph_q == lim);
  assign ph   = ph_q;

  always_comb begin
    ph_d = ph_q;
    if (clr)     ph_d = '0;
    else if (en) ph_d = wrap ? '0 : ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/cnv_spi_seq.sv
module cnv_spi_seq
  import cnv_spi_pkg::*;
#(
  parameter int LO_CYC  = 3,
  parameter int HI_CYC  = 2,
  parameter int NBITS   = 32,
  parameter int RD_BITS = 8,
  parameter int PH_W    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd_req,
  input  logic [PH_W-1:0] ph,
  input  logic            ph_wrap,
  output logic            ph_clr,
  output logic [PH_W-1:0] ph_lim,
  output logic            load,
  output logic            shift,
  output logic            sample,
  output logic            sel_on,
  output logic            sel_off,
  output logic            rd_cap,
  output logic            busy,
  output logic            done,
  output logic            oe,
  output logic            sclk
);
  localparam int PER      = LO_CYC + HI_CYC;
  localparam int HOLD_CYC = LO_CYC;
  localparam int GAP_CYC  = PER;
  localparam int BIT_W    = $clog2(NBITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NBITS - 1);
  localparam logic [BIT_W-1:0] TURN_BIT = BIT_W'(NBITS - RD_BITS - 1);

  seq_st_e          st_q, st_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             rd_q, rd_d;
  logic             oe_q, oe_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;

  assign busy = (st_q != SEQ_IDLE);
  assign done = done_q;
  assign oe   = oe_q;
  assign sclk = sclk_q;

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    rd_d    = rd_q;
    oe_d    = oe_q;
    sclk_d  = sclk_q;
    done_d  = 1'b0;
    ph_clr  = 1'b0;
    ph_lim  = '0;
    load    = 1'b0;
    shift   = 1'b0;
    sample  = 1'b0;
    sel_on  = 1'b0;
    sel_off = 1'b0;
    rd_cap  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        ph_clr = 1'b1;
        if (start) begin
          st_d   = SEQ_SHIFT;
          bit_d  = '0;
          rd_d   = rd_req;
          oe_d   = 1'b1;
          sclk_d = 1'b0;
          load   = 1'b1;
          sel_on = 1'b1;
        end
      end
      SEQ_SHIFT: begin
        ph_lim = PH_W'(PER - 1);
        if (ph == PH_W'(LO_CYC - 1)) begin
          sclk_d = 1'b1;
          sample = 1'b1;
        end
        if (ph_wrap) begin
          sclk_d = 1'b0;
          if (bit_q == LAST_BIT) begin
            st_d = SEQ_HOLD;
          end else begin
            bit_d = bit_q + BIT_W'(1);
            shift = 1'b1;
            if (rd_q && (bit_q == TURN_BIT)) oe_d = 1'b0;
          end
        end
      end
      SEQ_HOLD: begin
        ph_lim = PH_W'(HOLD_CYC - 1);
        if (ph_wrap) begin
          st_d    = SEQ_GAP;
          sel_off = 1'b1;
          done_d  = 1'b1;
          oe_d    = 1'b0;
          rd_cap  = rd_q;
        end
      end
      SEQ_GAP: begin
        ph_lim = PH_W'(GAP_CYC - 1);
        if (ph_wrap) st_d = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/cnv_spi_shreg.sv
module cnv_spi_shreg #(
  parameter int NBITS   = 32,
  parameter int RD_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [NBITS-1:0]   frame,
  input  logic               shift,
  input  logic               sample,
  input  logic               miso,
  input  logic               rd_cap,
  output logic               mosi,
  output logic [RD_BITS-1:0] rdata
);
  logic [NBITS-1:0]   tx_q, tx_d;
  logic [NBITS-1:0]   rx_q, rx_d;
  logic [RD_BITS-1:0] rd_q, rd_d;

  assign mosi  = tx_q[NBITS-1];
  assign rdata = rd_q;

  always_comb begin
    tx_d = tx_q;
    if (load)       tx_d = frame;
    else if (shift) tx_d = {tx_q[NBITS-2:0], 1'b0};
    rx_d = sample ? {rx_q[NBITS-2:0], miso} : rx_q;
    rd_d = rd_cap ? rx_q[RD_BITS-1:0] : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
      rd_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
      rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/cnv_spi_seldec.sv
module cnv_spi_seldec #(
  parameter int N_SEL = 3,
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_on,
  input  logic             sel_off,
  input  logic [TGT_W-1:0] tgt,
  output logic [N_SEL-1:0] cs_n
);
  logic [N_SEL-1:0] cs_q, cs_d;

  for (genvar i = 0; i < N_SEL; i++) begin : g_sel
    assign cs_d[i] = sel_on  ? (tgt != TGT_W'(i)) :
                     sel_off ? 1'b1 : cs_q[i];
  end

  assign cs_n = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= '1;
    else        cs_q <= cs_d;
  end
endmodule

// File: rtl/cnv_spi_master.sv
module cnv_spi_master #(
  parameter int PRESEL_W = 8,
  parameter int WID_W    = 2,
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int N_SLAVES = 3,
  parameter int TGT_W    = 2,
  parameter int LO_CYC   = 3,
  parameter int HI_CYC   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [TGT_W-1:0]    tgt,
  input  logic [PRESEL_W-1:0] presel,
  input  logic                rw,
  input  logic [WID_W-1:0]    width,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic                sclk,
  output logic [N_SLAVES-1:0] cs_n,
  output logic                mosi,
  input  logic                miso,
  output logic                oe
);
  localparam int NBITS = PRESEL_W + 1 + WID_W + ADDR_W + DATA_W;
  localparam int PH_W  = $clog2(LO_CYC + HI_CYC + 1);

  logic [NBITS-1:0] frame;
  logic [PH_W-1:0]  ph, ph_lim;
  logic             ph_wrap, ph_clr;
  logic             load, shift, sample, sel_on, sel_off, rd_cap;

  assign frame = {presel, rw, width, addr, wdata};

  cnv_spi_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(busy), .clr(ph_clr),
    .lim(ph_lim), .ph(ph), .wrap(ph_wrap)
  );

  cnv_spi_seq #(
    .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .NBITS(NBITS),
    .RD_BITS(DATA_W), .PH_W(PH_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rw),
    .ph(ph), .ph_wrap(ph_wrap), .ph_clr(ph_clr), .ph_lim(ph_lim),
    .load(load), .shift(shift), .sample(sample),
    .sel_on(sel_on), .sel_off(sel_off), .rd_cap(rd_cap),
    .busy(busy), .done(done), .oe(oe), .sclk(sclk)
  );

  cnv_spi_shreg #(.NBITS(NBITS), .RD_BITS(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .frame(frame),
    .shift(shift), .sample(sample), .miso(miso), .rd_cap(rd_cap),
    .mosi(mosi), .rdata(rdata)
  );

  cnv_spi_seldec #(.N_SEL(N_SLAVES), .TGT_W(TGT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_on(sel_on), .sel_off(sel_off),
    .tgt(tgt), .cs_n(cs_n)
  );
endmodule

// File: rtl/cnv_spi_master_chk.sv
module cnv_spi_master_chk #(
  parameter int N_SEL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             sclk,
  input logic [N_SEL-1:0] cs_n,
  input logic             mosi,
  input logic             oe
);
  p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_sel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  p_sclk_hi_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
  p_sclk_hi_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |=> !sclk);
  p_mosi_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  p_mosi_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_oe_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !oe);
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((&cs_n) && busy && !sclk));
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

bind cnv_spi_master cnv_spi_master_chk #(.N_SEL(N_SLAVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .oe(oe)
);

// File: tb/sim_cnv_spi_master.sv
module sim_cnv_spi_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  tgt = '0;
  logic [7:0]  presel = '0;
  logic        rw = 1'b0;
  logic [1:0]  width = '0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, done, sclk, mosi, oe;
  logic [7:0]  rdata;
  logic [2:0]  cs_n;
  logic        miso;

  int nvec = 0;
  int nerr = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  cnv_spi_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt(tgt), .presel(presel),
    .rw(rw), .width(width), .addr(addr), .wdata(wdata), .busy(busy),
    .done(done), .rdata(rdata), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .oe(oe)
  );

  // reference model: frame position counter and expected state
  int          mc = -1;
  logic [31:0] mframe = '0;
  logic        mrd = 1'b0;
  logic [1:0]  mtgt = '0;
  logic [7:0]  mrdata = '0;
  logic [31:0] mresp = '0;
  logic [31:0] resp_next = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc     <= -1;
      mrdata <= '0;
    end else if (mc < 0) begin
      if (start) begin
        mc     <= 0;
        mframe <= {presel, rw, width, addr, wdata};
        mrd    <= rw;
        mtgt   <= tgt;
        mresp  <= resp_next;
      end
    end else begin
      if (mc == 162 && mrd) mrdata <= mresp[7:0];
      mc <= (mc == 167) ? -1 : mc + 1;
    end
  end

  // behavioural slave: next bit after each sclk falling edge
  int nf = 0;
  always @(negedge sclk or negedge busy) begin
    if (!busy) nf <= 0;
    else       nf <= nf + 1;
  end
  assign miso = (nf < 32) ? mresp[31 - nf] : 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!ended) begin
      logic [2:0] e_cs;
      e_cs = 3'b111;
      if (mc >= 0 && mc <= 162 && mtgt < 2'd3) e_cs[mtgt] = 1'b0;
      if (!rst_n) begin
        chk("R11 reset cs_n",  32'(cs_n), 32'h7);
        chk("R11 reset sclk",  32'(sclk), 32'h0);
        chk("R11 reset oe",    32'(oe),   32'h0);
        chk("R11 reset busy",  32'(busy), 32'h0);
        chk("R11 reset done",  32'(done), 32'h0);
        chk("R11 reset rdata", 32'(rdata), 32'h0);
      end else begin
        chk("R5 R6 cs_n", 32'(cs_n), 32'(e_cs));
        chk("R2 sclk", 32'(sclk),
            32'(mc >= 0 && mc < 160 && (mc % 5) >= 3));
        chk("R7 oe", 32'(oe),
            32'(mc >= 0 && mc < 163 && (!mrd || mc < 120)));
        chk("R8 busy", 32'(busy), 32'(mc >= 0));
        chk("R9 done", 32'(done), 32'(mc == 163));
        chk("R4 R10 rdata", 32'(rdata), 32'(mrdata));
        if (mc >= 0 && mc < 160)
          chk("R1 R3 mosi", 32'(mosi), 32'(mframe[31 - mc / 5]));
      end
    end
  end

  task automatic set_req(input logic [1:0] t, input logic [7:0] p, input logic r,
                         input logic [1:0] w, input logic [12:0] a,
                         input logic [7:0] d, input logic [31:0] resp);
    tgt = t; presel = p; rw = r; width = w; addr = a; wdata = d;
    resp_next = resp;
  endtask

  task automatic frame(input logic [1:0] t, input logic [7:0] p, input logic r,
                       input logic [1:0] w, input logic [12:0] a,
                       input logic [7:0] d, input logic [31:0] resp);
    @(negedge clk);
    set_req(t, p, r, w, a, d, resp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (175) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 R5 writes to each target with distinct patterns
    frame(2'd0, 8'hA5, 1'b0, 2'b01, 13'h1ABC, 8'h3C, 32'h0);
    frame(2'd1, 8'h5A, 1'b0, 2'b10, 13'h0543, 8'hC3, 32'h0);
    frame(2'd2, 8'hFF, 1'b0, 2'b11, 13'h1FFF, 8'h00, 32'h0);
    // R4 R7 reads with slave responses
    frame(2'd1, 8'h81, 1'b1, 2'b00, 13'h0001, 8'h77, 32'hDEAD_BEC3);
    // R10 write after read keeps rdata
    frame(2'd0, 8'h00, 1'b0, 2'b00, 13'h0000, 8'hFF, 32'hFFFF_FFFF);
    frame(2'd2, 8'h3C, 1'b1, 2'b01, 13'h1000, 8'h11, 32'h1234_565A);
    // R5 target 3 selects nothing
    frame(2'd3, 8'h96, 1'b0, 2'b10, 13'h0AAA, 8'h69, 32'h0);
    // R8 competing starts in mid-frame are ignored
    @(negedge clk);
    set_req(2'd0, 8'h12, 1'b1, 2'b01, 13'h0123, 8'h45, 32'h0000_00A7);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    set_req(2'd2, 8'hEE, 1'b0, 2'b11, 13'h1555, 8'h99, 32'h0);
    start = 1'b1;
    repeat (130) @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    // R9 start held high: back-to-back frames with the gap enforced
    set_req(2'd1, 8'hC0, 1'b1, 2'b10, 13'h0F0F, 8'h0F, 32'h5555_5581);
    start = 1'b1;
    repeat (200) @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nerr++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule